// File: doc/BRIEF.md
# Flag Offset Sequential Loader

This block keeps the almost-empty offset (n) and the almost-full offset (m) for one FIFO. It lets them be programmed and read back through one load strobe with rotating register pointers, so no address bus is needed. The assembled n and m values go straight to the FIFO's flag comparators. The FIFO storage and the flag comparisons are outside this block.

Each offset is split into an 8-bit low byte and a high part. The high part is `$clog2(DEPTH) - 8` bits wide, and it is absent at a depth of 256. Writes step through four registers in a fixed order: empty low, empty high, full low, full high. Readback steps through the same order with its own pointer. Programming can stop after any register and later pick up at the next one.

The load path only works when programmable-flag mode was chosen during reset. The mode is chosen by holding the load strobe low while reset is asserted. Read and write share one clock, so the read clock is tied to the write clock. The reset input is asserted asynchronously, and its release is synchronized inside the block.

Top module: `flag_ofs_loader`

## Requirements
- R1: After reset, both offsets equal 7, both pointers select the empty-low register, `rd_data` is 0, and `rd_valid` and `collide` are 0.
- R2: In programmable mode, each rising edge with `ld_n`=0 and `wen1_n`=0 writes `din` into the register at the write pointer and advances the pointer. The order is 0 = empty low, 1 = empty high, 2 = full low, 3 = full high.
- R3: The fifth write after reset lands in the empty-low register again, because the write pointer wraps from 3 to 0.
- R4: With `ld_n`=0 and `wen1_n`=1, no offset changes and the write pointer holds.
- R5: After `ld_n` rises and then falls again, the next load write goes to the register after the last one written. The sequence does not restart at the first register.
- R6: A rising edge with `ld_n`=0, `ren1_n`=0 and `ren2_n`=0, and no write, loads the register at the read pointer into `rd_data`, zero-extended. It pulses `rd_valid` for one cycle and advances the read pointer, which also wraps from 3 to 0.
- R7: A low-byte register stores `din[7:0]` and a high-part register stores `din[OFS_W-9:0]`. All other `din` bits are dropped. `empty_ofs` and `full_ofs` are {high, low}.
- R8: If a write and a read are both requested on one edge, the write is done, the read pointer and `rd_data` hold, `rd_valid` stays 0, and `collide` is 1 for the following cycle.
- R9: If `ld_n` was 1 during reset, `prog_mode` is 0, the offsets stay at 7, and no load write or readback happens.
- R10: With `ld_n`=1, the enables have no effect on the offsets or on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared read/write clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronized |
| ld_n | input | 1 | Load strobe, active low; its level during reset selects the mode |
| wen1_n | input | 1 | Write enable, active low |
| ren1_n | input | 1 | Read enable 1, active low |
| ren2_n | input | 1 | Read enable 2, active low |
| din | input | DW | Data bus for offset writes |
| rd_data | output | DW | Readback output register |
| rd_valid | output | 1 | One-cycle pulse when `rd_data` was reloaded |
| collide | output | 1 | One-cycle pulse after a simultaneous read and write request |
| prog_mode | output | 1 | Programmable-flag mode latched at reset |
| empty_ofs | output | OFS_W | Assembled almost-empty offset n |
| full_ofs | output | OFS_W | Assembled almost-full offset m |

## Verification
The hardest state to reach is a collision that happens while the two pointers point at different registers. In that state, a read pointer that wrongly advanced, or a read that wrongly won, would show up as a different readback word.

The stimulus first does seven load writes, wrapping once and stopping partway, so the write pointer ends at 3. It then does five reads, so the read pointer wraps and ends at 1. Only then does it raise both requests together. The next plain read must return the empty-high register, and the full-high register must hold the value from the colliding write.

// File: rtl/ofs_ld_pkg.sv
package ofs_ld_pkg;
  typedef enum logic [1:0] {
    SEL_E_LO = 2'd0,
    SEL_E_HI = 2'd1,
    SEL_F_LO = 2'd2,
    SEL_F_HI = 2'd3
  } sel_e;

  localparam int            LO_W       = 8;
  localparam logic [LO_W-1:0] LO_DEFAULT = 8'd7;

  function automatic sel_e sel_next(input sel_e s);
    logic [1:0] t;
    t = s + 2'd1;
    return sel_e'(t);
  endfunction
endpackage

// File: rtl/ofs_ld_ctrl.sv
module ofs_ld_ctrl
  import ofs_ld_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ld_n,
  input  logic wen1_n,
  input  logic ren1_n,
  input  logic ren2_n,
  output logic prog_mode,
  output logic wr_go,
  output logic rd_go,
  output sel_e wr_sel,
  output sel_e rd_sel,
  output logic collide
);
  logic mode_q;
  logic wr_req, rd_req;
  sel_e wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic collide_q, collide_d;

  // mode pin sampled on every edge while reset is held
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= ~ld_n;
  end

  always_comb begin
    wr_req    = mode_q & ~ld_n & ~wen1_n;
    rd_req    = mode_q & ~ld_n & ~ren1_n & ~ren2_n;
    wr_go     = wr_req;
    rd_go     = rd_req & ~wr_req;
    wr_ptr_d  = wr_go ? sel_next(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d  = rd_go ? sel_next(rd_ptr_q) : rd_ptr_q;
    collide_d = wr_req & rd_req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q  <= SEL_E_LO;
      rd_ptr_q  <= SEL_E_LO;
      collide_q <= 1'b0;
    end else begin
      wr_ptr_q  <= wr_ptr_d;
      rd_ptr_q  <= rd_ptr_d;
      collide_q <= collide_d;
    end
  end

  assign prog_mode = mode_q;
  assign wr_sel    = wr_ptr_q;
  assign rd_sel    = rd_ptr_q;
  assign collide   = collide_q;

  assert_rdptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && rd_req) |=> (rd_ptr_q == $past(rd_ptr_q)));
  assert_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && wr_ptr_q == SEL_F_HI) |=> (wr_ptr_q == SEL_E_LO));
  assert_wrptr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wen1_n || ld_n) |=> $stable(wr_ptr_q));
endmodule

// File: rtl/ofs_ld_bank.sv
module ofs_ld_bank
  import ofs_ld_pkg::*;
#(
  parameter int OFS_W = 10,
  parameter int DW    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_go,
  input  sel_e             wr_sel,
  input  logic [DW-1:0]    din,
  input  sel_e             rd_sel,
  output logic [OFS_W-1:0] empty_ofs,
  output logic [OFS_W-1:0] full_ofs,
  output logic [DW-1:0]    rd_word
);
  localparam int HI_W = OFS_W - LO_W;

  logic [LO_W-1:0] e_lo_q, e_lo_d, f_lo_q, f_lo_d;
  logic [DW-1:0]   e_lo_w, f_lo_w, e_hi_w, f_hi_w;
  logic            unused_din;

  assign unused_din = ^din;

  always_comb begin
    e_lo_d = e_lo_q;
    f_lo_d = f_lo_q;
    if (wr_go && wr_sel == SEL_E_LO) e_lo_d = din[LO_W-1:0];
    if (wr_go && wr_sel == SEL_F_LO) f_lo_d = din[LO_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_lo_q <= LO_DEFAULT;
      f_lo_q <= LO_DEFAULT;
    end else begin
      e_lo_q <= e_lo_d;
      f_lo_q <= f_lo_d;
    end
  end

  assign e_lo_w = {{(DW-LO_W){1'b0}}, e_lo_q};
  assign f_lo_w = {{(DW-LO_W){1'b0}}, f_lo_q};

  generate
    if (HI_W > 0) begin : g_hi
      logic [HI_W-1:0] e_hi_q, e_hi_d, f_hi_q, f_hi_d;

      always_comb begin
        e_hi_d = e_hi_q;
        f_hi_d = f_hi_q;
        if (wr_go && wr_sel == SEL_E_HI) e_hi_d = din[HI_W-1:0];
        if (wr_go && wr_sel == SEL_F_HI) f_hi_d = din[HI_W-1:0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          e_hi_q <= '0;
          f_hi_q <= '0;
        end else begin
          e_hi_q <= e_hi_d;
          f_hi_q <= f_hi_d;
        end
      end

      assign empty_ofs = {e_hi_q, e_lo_q};
      assign full_ofs  = {f_hi_q, f_lo_q};
      assign e_hi_w    = {{(DW-HI_W){1'b0}}, e_hi_q};
      assign f_hi_w    = {{(DW-HI_W){1'b0}}, f_hi_q};
    end else begin : g_nohi
      assign empty_ofs = e_lo_q;
      assign full_ofs  = f_lo_q;
      assign e_hi_w    = '0;
      assign f_hi_w    = '0;
    end
  endgenerate

  always_comb begin
    unique case (rd_sel)
      SEL_E_LO: rd_word = e_lo_w;
      SEL_E_HI: rd_word = e_hi_w;
      SEL_F_LO: rd_word = f_lo_w;
      default:  rd_word = f_hi_w;
    endcase
  end

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_go |=> ($stable(empty_ofs) && $stable(full_ofs)));
  assert_one_side_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && (wr_sel == SEL_E_LO || wr_sel == SEL_E_HI)) |=> $stable(full_ofs));
endmodule

// File: rtl/ofs_ld_rdreg.sv
module ofs_ld_rdreg #(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_go,
  input  logic [DW-1:0] rd_word,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);
  logic [DW-1:0] data_q, data_d;
  logic          vld_q;

  always_comb data_d = rd_go ? rd_word : data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      data_q <= data_d;
      vld_q  <= rd_go;
    end
  end

  assign rd_data  = data_q;
  assign rd_valid = vld_q;

  assert_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_data));
endmodule

// File: rtl/flag_ofs_loader.sv
module flag_ofs_loader
  import ofs_ld_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int DW    = 9
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ld_n,
  input  logic                      wen1_n,
  input  logic                      ren1_n,
  input  logic                      ren2_n,
  input  logic [DW-1:0]             din,
  output logic [DW-1:0]             rd_data,
  output logic                      rd_valid,
  output logic                      collide,
  output logic                      prog_mode,
  output logic [$clog2(DEPTH)-1:0]  empty_ofs,
  output logic [$clog2(DEPTH)-1:0]  full_ofs
);
  localparam int OFS_W = $clog2(DEPTH);
  localparam logic [OFS_W-1:0] OFS_DEFAULT = OFS_W'(LO_DEFAULT);

  logic [1:0]    rst_pipe_q;
  logic          rst_q_n;
  logic          wr_go, rd_go;
  sel_e          wr_sel, rd_sel;
  logic [DW-1:0] rd_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_q_n = rst_pipe_q[1];

  ofs_ld_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_q_n), .ld_n(ld_n), .wen1_n(wen1_n),
    .ren1_n(ren1_n), .ren2_n(ren2_n), .prog_mode(prog_mode),
    .wr_go(wr_go), .rd_go(rd_go), .wr_sel(wr_sel), .rd_sel(rd_sel),
    .collide(collide)
  );

  ofs_ld_bank #(.OFS_W(OFS_W), .DW(DW)) u_bank (
    .clk(clk), .rst_n(rst_q_n), .wr_go(wr_go), .wr_sel(wr_sel),
    .din(din), .rd_sel(rd_sel), .empty_ofs(empty_ofs),
    .full_ofs(full_ofs), .rd_word(rd_word)
  );

  ofs_ld_rdreg #(.DW(DW)) u_rdreg (
    .clk(clk), .rst_n(rst_q_n), .rd_go(rd_go), .rd_word(rd_word),
    .rd_data(rd_data), .rd_valid(rd_valid)
  );

  assert_defaults_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !prog_mode |-> (empty_ofs == OFS_DEFAULT && full_ofs == OFS_DEFAULT && !rd_valid));
  assert_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    collide |-> !rd_valid);
  assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    ld_n |=> (!rd_valid && $stable(empty_ofs) && $stable(full_ofs)));
endmodule

// File: tb/sim_flag_ofs_loader.sv
module sim_flag_ofs_loader;
  logic       clk = 1'b0;
  logic       rst_n, ld_n, wen1_n, ren1_n, ren2_n;
  logic [8:0] din, rd_data;
  logic       rd_valid, collide, prog_mode;
  logic [9:0] empty_ofs, full_ofs;
  int         total = 0, fails = 0;

  always #10 clk = ~clk;

  flag_ofs_loader u0 (
    .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .wen1_n(wen1_n),
    .ren1_n(ren1_n), .ren2_n(ren2_n), .din(din), .rd_data(rd_data),
    .rd_valid(rd_valid), .collide(collide), .prog_mode(prog_mode),
    .empty_ofs(empty_ofs), .full_ofs(full_ofs)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic prog);
    @(negedge clk);
    ld_n = ~prog; wen1_n = 1; ren1_n = 1; ren2_n = 1; din = '0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    ld_n = 1;
  endtask

  task automatic ld_write(input logic [8:0] d);
    ld_n = 0; wen1_n = 0; din = d;
    @(negedge clk);
    wen1_n = 1;
  endtask

  task automatic ld_read(output logic [8:0] d, output logic v);
    ld_n = 0; ren1_n = 0; ren2_n = 0;
    @(negedge clk);
    d = rd_data; v = rd_valid;
    ren1_n = 1; ren2_n = 1;
  endtask

  task automatic t_reset;
    do_reset(1'b1);
    check("R1 empty_ofs", empty_ofs, 10'd7);
    check("R1 full_ofs", full_ofs, 10'd7);
    check("R1 rd_data", rd_data, 0);
    check("R1 rd_valid/collide", {rd_valid, collide}, 0);
    check("R9 prog_mode set", prog_mode, 1);
  endtask

  task automatic t_sequence;
    ld_write(9'h1A5);
    check("R2 first write empty low", empty_ofs, 10'h0A5);
    ld_write(9'h1FE);
    ld_write(9'h033);
    ld_write(9'h101);
    check("R2 R7 empty_ofs", empty_ofs, 10'h2A5);
    check("R2 R7 full_ofs", full_ofs, 10'h133);
    ld_write(9'h011);
    check("R3 wrap empty_ofs", empty_ofs, 10'h211);
    check("R3 wrap full unchanged", full_ofs, 10'h133);
  endtask

  task automatic t_nop_resume;
    ld_n = 0; wen1_n = 1;
    for (int i = 0; i < 3; i++) begin
      din = 9'(i * 37 + 5);
      @(negedge clk);
    end
    check("R4 no-op empty", empty_ofs, 10'h211);
    check("R4 no-op full", full_ofs, 10'h133);
    ld_write(9'h003);
    check("R4 pointer held", empty_ofs, 10'h311);
    ld_n = 1; wen1_n = 0; din = 9'h0FF;
    repeat (2) @(negedge clk);
    wen1_n = 1;
    check("R10 ld high empty", empty_ofs, 10'h311);
    check("R10 ld high full", full_ofs, 10'h133);
    ld_write(9'h0C0);
    check("R5 resume at full low", full_ofs, 10'h1C0);
    ld_n = 1;
  endtask

  task automatic t_readback;
    logic [8:0] d; logic v;
    logic [8:0] exp [5] = '{9'h011, 9'h003, 9'h0C0, 9'h001, 9'h011};
    @(negedge clk);
    check("R6 idle rd_valid", rd_valid, 0);
    for (int i = 0; i < 5; i++) begin
      ld_read(d, v);
      check("R6 readback word", d, exp[i]);
      check("R6 readback valid", v, 1);
    end
    ld_n = 1;
    @(negedge clk);
    check("R6 valid is a pulse", rd_valid, 0);
  endtask

  task automatic t_collide;
    logic [8:0] d; logic v;
    ld_n = 0; wen1_n = 0; ren1_n = 0; ren2_n = 0; din = 9'h002;
    @(negedge clk);
    wen1_n = 1; ren1_n = 1; ren2_n = 1;
    check("R8 collide pulse", collide, 1);
    check("R8 no read valid", rd_valid, 0);
    check("R8 rd_data held", rd_data, 9'h011);
    check("R8 write done", full_ofs, 10'h2C0);
    @(negedge clk);
    check("R8 collide clears", collide, 0);
    ld_read(d, v);
    check("R8 read pointer held", d, 9'h003);
    ld_n = 1;
  endtask

  task automatic t_pointer_reset;
    logic [8:0] d; logic v;
    do_reset(1'b1);
    ld_write(9'h044);
    check("R1 write pointer cleared", empty_ofs, 10'h044);
    ld_n = 1;
    @(negedge clk);
    ld_read(d, v);
    check("R1 read pointer cleared", d, 9'h044);
    ld_n = 1;
  endtask

  task automatic t_mode_off;
    logic [8:0] d; logic v;
    do_reset(1'b0);
    check("R9 prog_mode clear", prog_mode, 0);
    ld_write(9'h0AA);
    ld_write(9'h1FF);
    check("R9 empty default", empty_ofs, 10'd7);
    check("R9 full default", full_ofs, 10'd7);
    ld_read(d, v);
    check("R9 no readback", {v, d}, 0);
    ld_n = 1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    rst_n = 0; ld_n = 1; wen1_n = 1; ren1_n = 1; ren2_n = 1; din = '0;
    t_reset();
    t_sequence();
    t_nop_resume();
    t_readback();
    t_collide();
    t_pointer_reset();
    t_mode_off();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule